// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select timing for one SPI master frame. The clock period and each of three delays is a product of two factors, each chosen by a small index field: an odd or small prescaler taken from a four-entry set, and a larger scaler taken from a sixteen-entry set. The three delays are the chip-select setup time before the first clock edge, the hold time after the last clock edge, and the idle gap after the frame.

Software picks all index fields, the clock polarity and the frame length. It then pulses a start input. The block latches the whole selection and runs the setup delay, the shift phase, the hold delay and the gap in that fixed order. It gives a one-cycle strobe for every clock edge and for the end of every delay. A shift engine next to it uses these strobes to move data bits and drive the chip select. Index fields that change during a frame only apply to the next frame.

Top module: `spi_timing_gen`

## Requirements
- R1: Clock prescaler index 0, 1, 2, 3 selects the factor 2, 3, 5, 7.
- R2: Clock scaler index 0 to 3 selects 2, 4, 6, 8. Index k from 4 to 15 selects 2 to the power k (16 up to 32768).
- R3: During the shift phase each bit lasts P = prescaler × scaler clock cycles. The first P/2 cycles have sck at the active level (inverse of the polarity) and the last P/2 cycles have sck at the polarity level. A frame has frame_len_i + 1 bits.
- R4: Delay prescaler index 0, 1, 2, 3 selects 1, 3, 5, 7. Delay scaler index j selects 2 shifted left by j (2 up to 65536). Each delay lasts prescaler × scaler cycles.
- R5: start_i is sampled high at a clock edge while idle. From the next cycle the block runs, in order, the setup delay, the shift phase, the hold delay and the gap. Each delay-done output is high for exactly the last cycle of its own delay. busy_o is high from the cycle after start through the cycle of the gap-done pulse, and low in the cycle after it.
- R6: While idle, sck_o holds the polarity input of the previous cycle. During a frame, outside the active halves, it holds the polarity latched at start.
- R7: sck_lead_o is a one-cycle pulse in the first cycle of every active half. sck_trail_o is a one-cycle pulse in the first cycle of every idle half.
- R8: While busy, changes on start_i, the polarity, the frame length or any index field have no effect on the running frame.
- R9: Index 15 gives the slowest setting. Clock scaler 15 with prescaler 2 gives a 65536-cycle bit, and delay scaler 15 with prescaler 1 gives a 65536-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, taken only while idle |
| frame_len_i | input | LEN_W | Number of bits in the frame minus one |
| cpol_i | input | 1 | Clock polarity (idle level of sck) |
| baud_pre_i | input | 2 | Clock prescaler index |
| baud_scl_i | input | 4 | Clock scaler index |
| csd_pre_i | input | 2 | Setup delay prescaler index |
| csd_scl_i | input | 4 | Setup delay scaler index |
| asd_pre_i | input | 2 | Hold delay prescaler index |
| asd_scl_i | input | 4 | Hold delay scaler index |
| ftd_pre_i | input | 2 | Gap delay prescaler index |
| ftd_scl_i | input | 4 | Gap delay scaler index |
| busy_o | output | 1 | Frame in progress |
| sck_o | output | 1 | Serial clock |
| sck_lead_o | output | 1 | Strobe: sck entered its active level |
| sck_trail_o | output | 1 | Strobe: sck returned to its idle level |
| csd_done_o | output | 1 | Last cycle of the setup delay |
| asd_done_o | output | 1 | Last cycle of the hold delay |
| ftd_done_o | output | 1 | Last cycle of the gap delay |

## Verification
The bench builds the block with MAX_BITS = 8, so a 3-bit length field covers every frame length from one to eight bits, including the wrap at the field maximum. Counters keep their full default width. This lets one directed frame use scaler index 15 for both the clock and the setup delay at the full 65536-cycle length. Random frames use the low scaler indices with every prescaler and polarity, and each one is compared cycle by cycle against a model. Some random frames also change the inputs and pulse start in the middle of the frame.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

   // Longest product: prescaler 7 times delay scaler 65536.
   localparam int MAX_PRE   = 7;
   localparam int MAX_SCALE = 65536;
   localparam int CNT_W     = $clog2(MAX_PRE * MAX_SCALE + 1);

   localparam int NSEL     = 4;
   localparam int SEL_BAUD = 0;
   localparam int SEL_CSD  = 1;
   localparam int SEL_ASD  = 2;
   localparam int SEL_FTD  = 3;

   typedef struct packed {
      logic [1:0] pre;
      logic [3:0] scl;
   } scale_sel_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL,
      ST_GAP
   } tgen_state_e;

endpackage

// File: rtl/spi_tgen_scale.sv
module spi_tgen_scale
   import spi_tgen_pkg::*;
#(
   parameter bit IS_BAUD = 1'b0
) (
   input  scale_sel_t       sel_i,
   output logic [CNT_W-1:0] prod_o
);

   logic [2:0]       pre_v;
   logic [CNT_W-1:0] scl_v;

   generate
      if (IS_BAUD) begin : g_baud
         always_comb begin
            case (sel_i.pre)
               2'd0:    pre_v = 3'd2;
               2'd1:    pre_v = 3'd3;
               2'd2:    pre_v = 3'd5;
               default: pre_v = 3'd7;
            endcase
            if (sel_i.scl < 4'd4) begin
               // linear low end: 2, 4, 6, 8
               scl_v = CNT_W'({sel_i.scl[1:0], 1'b0}) + CNT_W'(2);
            end else begin
               // power-of-two upper end: 16 .. 32768
               scl_v = CNT_W'(1) << sel_i.scl;
            end
         end
      end else begin : g_delay
         always_comb begin
            // odd factors 1, 3, 5, 7
            pre_v = {sel_i.pre, 1'b1};
            scl_v = CNT_W'(2) << sel_i.scl;
         end
      end
   endgenerate

   assign prod_o = scl_v * CNT_W'(pre_v);

endmodule

// File: rtl/spi_tgen_cnt.sv
module spi_tgen_cnt #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         ld_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (ld_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
   import spi_tgen_pkg::*;
#(
   parameter  int MAX_BITS = 32,
   localparam int LEN_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [LEN_W-1:0] frame_len_i,
   input  logic             cpol_i,
   input  logic [1:0]       baud_pre_i,
   input  logic [3:0]       baud_scl_i,
   input  logic [1:0]       csd_pre_i,
   input  logic [3:0]       csd_scl_i,
   input  logic [1:0]       asd_pre_i,
   input  logic [3:0]       asd_scl_i,
   input  logic [1:0]       ftd_pre_i,
   input  logic [3:0]       ftd_scl_i,
   output logic             busy_o,
   output logic             sck_o,
   output logic             sck_lead_o,
   output logic             sck_trail_o,
   output logic             csd_done_o,
   output logic             asd_done_o,
   output logic             ftd_done_o
);

   generate
      if (MAX_BITS < 1 || MAX_BITS > 65536) begin : g_bad_bits
         $error("spi_timing_gen: MAX_BITS out of range");
      end
   endgenerate

   tgen_state_e      state_q, state_d;
   scale_sel_t       cfg_in  [NSEL];
   scale_sel_t       cfg_q   [NSEL];
   logic [CNT_W-1:0] prod    [NSEL];
   logic             cpol_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] bit_q, bit_d;
   logic             half_q, half_d;
   logic             sck_q, sck_d;
   logic             lead_q, lead_d;
   logic             trail_q, trail_d;
   logic             take;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             zero;
   logic [CNT_W-1:0] half_len;

   assign cfg_in[SEL_BAUD] = '{pre: baud_pre_i, scl: baud_scl_i};
   assign cfg_in[SEL_CSD]  = '{pre: csd_pre_i,  scl: csd_scl_i};
   assign cfg_in[SEL_ASD]  = '{pre: asd_pre_i,  scl: asd_scl_i};
   assign cfg_in[SEL_FTD]  = '{pre: ftd_pre_i,  scl: ftd_scl_i};

   // While idle the live fields feed the scalers so the first delay loads
   // in the start cycle; afterwards only the latched copy is seen.
   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_scale
         spi_tgen_scale #(
            .IS_BAUD (g == SEL_BAUD)
         ) u_scale (
            .sel_i  ((state_q == ST_IDLE) ? cfg_in[g] : cfg_q[g]),
            .prod_o (prod[g])
         );
      end
   endgenerate

   // Every clock product is even, so both halves are equal.
   assign half_len = prod[SEL_BAUD] >> 1;

   spi_tgen_cnt #(
      .W (CNT_W)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (ld),
      .val_i  (ld_val),
      .zero_o (zero)
   );

   always_comb begin
      state_d = state_q;
      bit_d   = bit_q;
      half_d  = half_q;
      sck_d   = sck_q;
      lead_d  = 1'b0;
      trail_d = 1'b0;
      take    = 1'b0;
      ld      = 1'b0;
      ld_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            sck_d = cpol_i;
            if (start_i) begin
               take    = 1'b1;
               state_d = ST_LEAD;
               ld      = 1'b1;
               ld_val  = prod[SEL_CSD] - CNT_W'(1);
            end
         end
         ST_LEAD: begin
            if (zero) begin
               state_d = ST_SHIFT;
               ld      = 1'b1;
               ld_val  = half_len - CNT_W'(1);
               sck_d   = ~cpol_q;
               lead_d  = 1'b1;
               half_d  = 1'b0;
               bit_d   = '0;
            end
         end
         ST_SHIFT: begin
            if (zero) begin
               if (!half_q) begin
                  half_d  = 1'b1;
                  sck_d   = cpol_q;
                  trail_d = 1'b1;
                  ld      = 1'b1;
                  ld_val  = half_len - CNT_W'(1);
               end else if (bit_q == len_q) begin
                  state_d = ST_TRAIL;
                  ld      = 1'b1;
                  ld_val  = prod[SEL_ASD] - CNT_W'(1);
               end else begin
                  bit_d  = bit_q + 1'b1;
                  half_d = 1'b0;
                  sck_d  = ~cpol_q;
                  lead_d = 1'b1;
                  ld     = 1'b1;
                  ld_val = half_len - CNT_W'(1);
               end
            end
         end
         ST_TRAIL: begin
            if (zero) begin
               state_d = ST_GAP;
               ld      = 1'b1;
               ld_val  = prod[SEL_FTD] - CNT_W'(1);
            end
         end
         ST_GAP: begin
            if (zero) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         half_q  <= 1'b0;
         sck_q   <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         cpol_q  <= 1'b0;
         len_q   <= '0;
         for (int i = 0; i < NSEL; i++) begin
            cfg_q[i] <= '0;
         end
      end else begin
         state_q <= state_d;
         bit_q   <= bit_d;
         half_q  <= half_d;
         sck_q   <= sck_d;
         lead_q  <= lead_d;
         trail_q <= trail_d;
         if (take) begin
            cpol_q <= cpol_i;
            len_q  <= frame_len_i;
            for (int i = 0; i < NSEL; i++) begin
               cfg_q[i] <= cfg_in[i];
            end
         end
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign sck_o       = sck_q;
   assign sck_lead_o  = lead_q;
   assign sck_trail_o = trail_q;
   assign csd_done_o  = (state_q == ST_LEAD)  && zero;
   assign asd_done_o  = (state_q == ST_TRAIL) && zero;
   assign ftd_done_o  = (state_q == ST_GAP)   && zero;

endmodule

// File: rtl/spi_timing_gen_chk.sv
module spi_timing_gen_chk
   import spi_tgen_pkg::*;
(
   input logic       clk_i,
   input logic       rst_ni,
   input logic       start_i,
   input logic       cpol_i,
   input logic       busy_o,
   input logic       sck_o,
   input logic       sck_lead_o,
   input logic       sck_trail_o,
   input logic       csd_done_o,
   input logic       asd_done_o,
   input logic       ftd_done_o,
   input logic       cpol_q,
   input scale_sel_t baud_q
);

   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
   end

   // R5: phase events never coincide
   p_single_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({csd_done_o, asd_done_o, ftd_done_o, sck_lead_o, sck_trail_o}));

   // R5: gap end returns the block to idle
   p_gap_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ftd_done_o |=> !busy_o);

   // R7: lead strobe marks a move to the active level
   p_lead_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && sck_lead_o) |-> (sck_o != $past(sck_o)) && (sck_o != cpol_q));

   // R7: trail strobe marks a return to the idle level
   p_trail_home_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && sck_trail_o) |-> (sck_o != $past(sck_o)) && (sck_o == cpol_q));

   // R6: idle clock follows the polarity input
   p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && !busy_o && !$past(busy_o)) |-> (sck_o == $past(cpol_i)));

   // R8: start while busy does not end or restart a frame
   p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && !ftd_done_o) |=> busy_o);

   // R8: latched clock selection stays fixed across a frame
   p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && busy_o && $past(busy_o)) |-> $stable(baud_q));

endmodule

bind spi_timing_gen spi_timing_gen_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .cpol_i      (cpol_i),
   .busy_o      (busy_o),
   .sck_o       (sck_o),
   .sck_lead_o  (sck_lead_o),
   .sck_trail_o (sck_trail_o),
   .csd_done_o  (csd_done_o),
   .asd_done_o  (asd_done_o),
   .ftd_done_o  (ftd_done_o),
   .cpol_q      (cpol_q),
   .baud_q      (cfg_q[0])
);

// File: tb/spi_timing_gen_tb_top.sv
module spi_timing_gen_tb_top;

   localparam int MAX_BITS = 8;
   localparam int LEN_W    = 3;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             start_i = 1'b0;
   logic [LEN_W-1:0] frame_len_i = '0;
   logic             cpol_i = 1'b0;
   logic [1:0]       baud_pre_i = '0;
   logic [3:0]       baud_scl_i = '0;
   logic [1:0]       csd_pre_i = '0;
   logic [3:0]       csd_scl_i = '0;
   logic [1:0]       asd_pre_i = '0;
   logic [3:0]       asd_scl_i = '0;
   logic [1:0]       ftd_pre_i = '0;
   logic [3:0]       ftd_scl_i = '0;
   logic             busy_o, sck_o, sck_lead_o, sck_trail_o;
   logic             csd_done_o, asd_done_o, ftd_done_o;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #10 clk_i = ~clk_i;

   spi_timing_gen #(.MAX_BITS(MAX_BITS)) dut_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .frame_len_i (frame_len_i),
      .cpol_i      (cpol_i),
      .baud_pre_i  (baud_pre_i),
      .baud_scl_i  (baud_scl_i),
      .csd_pre_i   (csd_pre_i),
      .csd_scl_i   (csd_scl_i),
      .asd_pre_i   (asd_pre_i),
      .asd_scl_i   (asd_scl_i),
      .ftd_pre_i   (ftd_pre_i),
      .ftd_scl_i   (ftd_scl_i),
      .busy_o      (busy_o),
      .sck_o       (sck_o),
      .sck_lead_o  (sck_lead_o),
      .sck_trail_o (sck_trail_o),
      .csd_done_o  (csd_done_o),
      .asd_done_o  (asd_done_o),
      .ftd_done_o  (ftd_done_o)
   );

   function automatic int clk_pre(int i);
      case (i)
         0: return 2;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int clk_scl(int i);
      case (i)
         0: return 2;       1: return 4;       2: return 6;       3: return 8;
         4: return 16;      5: return 32;      6: return 64;      7: return 128;
         8: return 256;     9: return 512;     10: return 1024;   11: return 2048;
         12: return 4096;   13: return 8192;   14: return 16384;  default: return 32768;
      endcase
   endfunction

   function automatic int dly_pre(int i);
      case (i)
         0: return 1;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int dly_scl(int j);
      return 2 * (1 << j);
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   task automatic drive(input int bp, bs, cp, ln, cdp, cds, adp, ads, fdp, fds);
      baud_pre_i  = 2'(bp);
      baud_scl_i  = 4'(bs);
      cpol_i      = 1'(cp);
      frame_len_i = LEN_W'(ln);
      csd_pre_i   = 2'(cdp);
      csd_scl_i   = 4'(cds);
      asd_pre_i   = 2'(adp);
      asd_scl_i   = 4'(ads);
      ftd_pre_i   = 2'(fdp);
      ftd_scl_i   = 4'(fds);
   endtask

   // One frame, compared cycle by cycle against the requirement model.
   task automatic run_frame(input int bp, bs, cp, ln, cdp, cds, adp, ads,
                            fdp, fds, input bit scramble, input string tag);
      int dcs, p, a, nb, das, ddt, total;
      int bad_sck, bad_stb, bad_dly, bad_busy;
      bad_sck = 0; bad_stb = 0; bad_dly = 0; bad_busy = 0;
      dcs   = dly_pre(cdp) * dly_scl(cds);
      das   = dly_pre(adp) * dly_scl(ads);
      ddt   = dly_pre(fdp) * dly_scl(fds);
      p     = clk_pre(bp) * clk_scl(bs);
      a     = p / 2;
      nb    = ln + 1;
      total = dcs + nb * p + das + ddt;
      drive(bp, bs, cp, ln, cdp, cds, adp, ads, fdp, fds);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int t = 1; t <= total + 1; t++) begin
         bit e_busy, e_sck, e_lead, e_trail, e_csd, e_asd, e_ftd;
         e_busy = (t <= total);
         e_sck = 1'(cp); e_lead = 0; e_trail = 0; e_csd = 0; e_asd = 0; e_ftd = 0;
         if (t <= dcs) begin
            e_csd = (t == dcs);
         end else if (t <= dcs + nb * p) begin
            int u, r;
            u = t - dcs - 1;
            r = u % p;
            e_sck   = (r < a) ? !1'(cp) : 1'(cp);
            e_lead  = (r == 0);
            e_trail = (r == a);
         end else if (t <= dcs + nb * p + das) begin
            e_asd = (t == dcs + nb * p + das);
         end else if (t <= total) begin
            e_ftd = (t == total);
         end
         if (sck_o !== e_sck) begin
            if (bad_sck == 0)
               $display("FAIL R3 R6 %s sck at t=%0d: actual %0d expected %0d", tag, t, sck_o, e_sck);
            bad_sck++;
         end
         if ({sck_lead_o, sck_trail_o} !== {e_lead, e_trail}) begin
            if (bad_stb == 0)
               $display("FAIL R7 %s strobes at t=%0d: actual %b expected %b", tag, t,
                        {sck_lead_o, sck_trail_o}, {e_lead, e_trail});
            bad_stb++;
         end
         if ({csd_done_o, asd_done_o, ftd_done_o} !== {e_csd, e_asd, e_ftd}) begin
            if (bad_dly == 0)
               $display("FAIL R4 R5 %s done at t=%0d: actual %b expected %b", tag, t,
                        {csd_done_o, asd_done_o, ftd_done_o}, {e_csd, e_asd, e_ftd});
            bad_dly++;
         end
         if (busy_o !== e_busy) begin
            if (bad_busy == 0)
               $display("FAIL R5 R8 %s busy at t=%0d: actual %0d expected %0d", tag, t, busy_o, e_busy);
            bad_busy++;
         end
         // R8: disturb every input in mid frame, then put it back
         if (scramble && t == dcs + 2) begin
            drive($urandom % 4, $urandom % 16, $urandom % 2, $urandom % 8,
                  $urandom % 4, $urandom % 16, $urandom % 4, $urandom % 16,
                  $urandom % 4, $urandom % 16);
            start_i = 1'b1;
         end
         if (scramble && t == dcs + 3) start_i = 1'b0;
         if (scramble && t == total - 1) drive(bp, bs, cp, ln, cdp, cds, adp, ads, fdp, fds);
         @(negedge clk_i);
      end
      check(bad_sck == 0,  {"R1 R2 R3 R6 sck waveform ", tag}, bad_sck, 0);
      check(bad_stb == 0,  {"R7 edge strobes ", tag}, bad_stb, 0);
      check(bad_dly == 0,  {"R4 R5 delay done pulses ", tag}, bad_dly, 0);
      check(bad_busy == 0, {"R5 R8 busy window ", tag}, bad_busy, 0);
   endtask

   initial begin
      repeat (198000) @(posedge clk_i);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed1));
      repeat (3) @(negedge clk_i);
      // reset state
      check(busy_o == 1'b0, "R5 busy in reset", busy_o, 0);
      check(sck_o == 1'b0, "R6 sck in reset", sck_o, 0);
      check({sck_lead_o, sck_trail_o, csd_done_o, asd_done_o, ftd_done_o} == 5'b0,
            "R7 strobes in reset", {sck_lead_o, sck_trail_o, csd_done_o, asd_done_o, ftd_done_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R6: idle level tracks polarity input
      cpol_i = 1'b1;
      repeat (2) @(negedge clk_i);
      check(sck_o == 1'b1 && busy_o == 1'b0, "R6 idle sck follows polarity", sck_o, 1);
      cpol_i = 1'b0;
      repeat (2) @(negedge clk_i);
      check(sck_o == 1'b0, "R6 idle sck follows polarity low", sck_o, 0);

      // directed corners
      run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, "minimum");
      run_frame(3, 3, 1, 7, 3, 1, 2, 2, 1, 3, 1'b0, "max prescalers full length cpol1");
      run_frame(1, 4, 0, 2, 1, 0, 0, 0, 0, 0, 1'b0, "R2 scaler 16");
      run_frame(0, 7, 1, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R2 scaler 128");
      run_frame(2, 2, 0, 3, 3, 3, 3, 3, 3, 3, 1'b1, "R8 scrambled");
      run_frame(0, 15, 0, 0, 0, 15, 0, 0, 0, 0, 1'b0, "R9 index 15");

      // constrained random frames
      for (int k = 0; k < 20; k++) begin
         run_frame($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 8,
                   $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
                   $urandom % 4, $urandom % 4, k[0], $sformatf("random %0d", k));
      end
      summary();
   end

endmodule